// File: doc/BRIEF.md
# Video Memory Write/Read Port with Tile-Order Address Remapping

This block sits between a CPU register bus and a 32K-word video memory built from 16-bit words, each word written one byte lane at a time. The CPU loads a 15-bit word pointer, then streams bytes into a low-lane or a high-lane data register. After each data access the pointer moves forward by a configurable step. The step is taken after either the low-lane access or the high-lane access, depending on a control bit. A remap option rotates the low bits of the pointer before they reach the memory. With it, a stream of sequential writes in bitmap order lands in the interleaved layout that tile graphics expect.

Reads go through a one-word prefetch register. It is reloaded from memory whenever the pointer is loaded, and again after each read that moves the pointer. A small state machine, `IDLE -> FETCH -> CAPTURE -> IDLE`, sequences each reload. In FETCH the block drives one read request. In CAPTURE it latches the returned word. A new trigger seen in FETCH or CAPTURE goes back to FETCH (transition "restart"). A trigger seen in IDLE takes the "start" transition. With no trigger, the machine takes "advance" from FETCH to CAPTURE and "finish" from CAPTURE to IDLE.

When blocking is enabled, a write made during active display is dropped, but the pointer still moves as though the write had happened. Active display means forced blank is off and the current line is below the visible height plus the first visible line.

Top module: `vport_vram_port`

## Requirements
- R1: After reset the pointer is 0, the control register is 0 and the prefetch word is 0. No memory write or read request is active.
- R2: Register select 3 is the low-lane data register and select 4 is the high-lane data register. In the cycle after either is written, the block drives `mem_wr_en=1` with the written byte on `mem_wr_data`. It drives the effective word address on `mem_wr_addr`, and `mem_wr_hi` is 1 only for select 4. The byte address is therefore the word address times 2, plus 1 for the high lane.
- R3: Control bit 7 chooses the lane that advances the pointer. When it is 0, accesses to selects 3 and 5 advance the pointer. When it is 1, accesses to selects 4 and 6 advance it. Accesses to the other lane leave the pointer unchanged.
- R4: Control bits [1:0] give the step size: code 0 is 1 word, code 1 is 32 words, and codes 2 and 3 are 128 words.
- R5: Control bits [3:2] select the remap mode, and mode 0 leaves the address unchanged. For modes 1, 2 and 3, take n = 5, 6 and 7 with mask m = 2^(n+3)-1 and r = addr & m. The effective address is then (addr & ~m) + (r >> n) + ((r & (2^n-1)) << 3). The same effective address is used for reads and for writes.
- R6: A data write is discarded when blocking is enabled, forced blank is low and `cur_line < vis_height + 1`. The pointer still advances exactly as in R3, and the memory word is left unchanged.
- R7: Writing select 1 loads pointer bits [7:0] and writing select 2 loads pointer bits [14:8]. Either write starts a prefetch, and three cycles later the prefetch word holds the memory word at the effective address.
- R8: Reading select 5 returns the low byte of the prefetch word and reading select 6 returns the high byte. A read that advances the pointer also starts a prefetch at the new pointer.
- R9: Writing the control register (select 0) leaves the pointer unchanged. The new step, lane and remap settings apply from the next data access.
- R10: The pointer wraps modulo 2^15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid while reg_rd is high |
| blk_en | input | 1 | Enable blocking of writes during active display |
| forced_blank | input | 1 | Display is forced blank |
| cur_line | input | 9 | Current scan line |
| vis_height | input | 9 | Number of visible lines |
| mem_wr_en | output | 1 | Memory byte write request |
| mem_wr_hi | output | 1 | Write targets the high lane |
| mem_wr_addr | output | 15 | Memory write word address |
| mem_wr_data | output | 8 | Memory write byte |
| mem_rd_en | output | 1 | Memory word read request |
| mem_rd_addr | output | 15 | Memory read word address |
| mem_rd_data | input | 16 | Memory read word, one cycle after mem_rd_en |

## Verification
The write path is driven with low-then-high pairs under both lane settings, which shows which access moves the pointer and whether the two lanes share a word. Repeated writes under each step code and each remap mode are compared against addresses computed from the rotation formula. A pointer near the top of the space checks the wrap. Blocking is exercised on both sides of the line boundary and with forced blank set. A read-back afterwards shows that a dropped write left memory intact. A pointer moved by a blocked write is told apart from one that did not move by the address of the next write. The read path is tried with advancing and non-advancing reads and with remapped pointers, which separates data from the old word and data from the refetched word.

// File: rtl/vport_pkg.sv
package vport_pkg;

    // Register select codes
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_PTR_L = 3'd1;
    localparam logic [2:0] SEL_PTR_H = 3'd2;
    localparam logic [2:0] SEL_WR_L  = 3'd3;
    localparam logic [2:0] SEL_WR_H  = 3'd4;
    localparam logic [2:0] SEL_RD_L  = 3'd5;
    localparam logic [2:0] SEL_RD_H  = 3'd6;

    // Remap geometry: mode m rotates the low (BASE_SHIFT+m+ROT_BITS) bits
    localparam int REMAP_BASE_SHIFT = 4;
    localparam int REMAP_ROT_BITS   = 3;
    localparam int REMAP_MODES      = 4;

    typedef struct packed {
        logic       inc_high;
        logic [1:0] remap;
        logic [1:0] step;
    } port_ctrl_t;

    typedef enum logic [1:0] {
        FS_IDLE    = 2'd0,
        FS_FETCH   = 2'd1,
        FS_CAPTURE = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/vport_remap.sv
module vport_remap
    import vport_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    logic [ADDR_W-1:0] cand [REMAP_MODES];

    assign cand[0] = addr_in;

    // Each mode is a left rotation of a low field by REMAP_ROT_BITS
    for (genvar m = 1; m < REMAP_MODES; m++) begin : g_mode
        localparam int SH = REMAP_BASE_SHIFT + m;
        localparam int FW = SH + REMAP_ROT_BITS;
        assign cand[m] = {addr_in[ADDR_W-1:FW], addr_in[SH-1:0], addr_in[FW-1:SH]};
    end

    assign addr_out = cand[mode];

endmodule

// File: rtl/vport_addr.sv
module vport_addr #(
    parameter int ADDR_W   = 15,
    parameter int BYTE_W   = 8,
    parameter int STEP_MID = 32,
    parameter int STEP_BIG = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] ld_data,
    input  logic              advance,
    input  logic [1:0]        step_code,
    output logic [ADDR_W-1:0] addr_q
);

    localparam int HI_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] step_amt;

    always_comb begin
        unique case (step_code)
            2'd0:    step_amt = ADDR_W'(1);
            2'd1:    step_amt = ADDR_W'(STEP_MID);
            default: step_amt = ADDR_W'(STEP_BIG);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_lo) begin
            addr_q[BYTE_W-1:0] <= ld_data;
        end else if (ld_hi) begin
            addr_q[ADDR_W-1:BYTE_W] <= ld_data[HI_W-1:0];
        end else if (advance) begin
            addr_q <= addr_q + step_amt;
        end
    end

endmodule

// File: rtl/vport_fetch_fsm.sv
module vport_fetch_fsm
    import vport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic rd_en,
    output logic capture
);

    fetch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:    state_d = start ? FS_FETCH : FS_IDLE;
            FS_FETCH:   state_d = start ? FS_FETCH : FS_CAPTURE;
            FS_CAPTURE: state_d = start ? FS_FETCH : FS_IDLE;
            default:    state_d = FS_IDLE;
        endcase
    end

    always_comb begin
        rd_en   = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            FS_FETCH:   rd_en   = 1'b1;
            FS_CAPTURE: capture = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/vport_vram_port.sv
module vport_vram_port
    import vport_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int BYTE_W     = 8,
    parameter int LINE_W     = 9,
    parameter int FIRST_LINE = 1,
    parameter int STEP_MID   = 32,
    parameter int STEP_BIG   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              blk_en,
    input  logic              forced_blank,
    input  logic [8:0]        cur_line,
    input  logic [8:0]        vis_height,
    output logic              mem_wr_en,
    output logic              mem_wr_hi,
    output logic [14:0]       mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    output logic              mem_rd_en,
    output logic [14:0]       mem_rd_addr,
    input  logic [15:0]       mem_rd_data
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [LINE_W:0] FIRST_L = (LINE_W+1)'(FIRST_LINE);

    port_ctrl_t          ctrl_q;
    logic                inc_high;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W-1:0]   eff_addr;
    logic [WORD_W-1:0]   prefetch_q;
    logic                fetch_rd, fetch_cap;

    // Access decode
    logic is_ctrl, is_ptr_l, is_ptr_h, is_wr_l, is_wr_h, is_rd_l, is_rd_h;
    assign is_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
    assign is_ptr_l = reg_wr && (reg_sel == SEL_PTR_L);
    assign is_ptr_h = reg_wr && (reg_sel == SEL_PTR_H);
    assign is_wr_l  = reg_wr && (reg_sel == SEL_WR_L);
    assign is_wr_h  = reg_wr && (reg_sel == SEL_WR_H);
    assign is_rd_l  = reg_rd && (reg_sel == SEL_RD_L);
    assign is_rd_h  = reg_rd && (reg_sel == SEL_RD_H);

    assign inc_high = ctrl_q.inc_high;

    logic advance, rd_advance, fetch_start, in_display;
    assign advance     = inc_high ? (is_wr_h || is_rd_h) : (is_wr_l || is_rd_l);
    assign rd_advance  = advance && (is_rd_l || is_rd_h);
    assign fetch_start = is_ptr_l || is_ptr_h || rd_advance;
    assign in_display  = !forced_blank &&
                         ({1'b0, cur_line} < ({1'b0, vis_height} + FIRST_L));

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (is_ctrl) begin
            ctrl_q.inc_high <= reg_wdata[7];
            ctrl_q.remap    <= reg_wdata[3:2];
            ctrl_q.step     <= reg_wdata[1:0];
        end
    end

    vport_addr #(
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W),
        .STEP_MID(STEP_MID),
        .STEP_BIG(STEP_BIG)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_lo    (is_ptr_l),
        .ld_hi    (is_ptr_h),
        .ld_data  (reg_wdata),
        .advance  (advance),
        .step_code(ctrl_q.step),
        .addr_q   (addr_q)
    );

    vport_remap #(
        .ADDR_W(ADDR_W)
    ) u_remap (
        .mode    (ctrl_q.remap),
        .addr_in (addr_q),
        .addr_out(eff_addr)
    );

    vport_fetch_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fetch_start),
        .rd_en  (fetch_rd),
        .capture(fetch_cap)
    );

    // Registered memory write request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_en   <= 1'b0;
            mem_wr_hi   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
        end else begin
            mem_wr_en <= (is_wr_l || is_wr_h) && !(blk_en && in_display);
            if (is_wr_l || is_wr_h) begin
                mem_wr_hi   <= is_wr_h;
                mem_wr_addr <= eff_addr;
                mem_wr_data <= reg_wdata;
            end
        end
    end

    // Prefetch word
    always_ff @(posedge clk) begin
        if (!rst_n)         prefetch_q <= '0;
        else if (fetch_cap) prefetch_q <= mem_rd_data;
    end

    assign mem_rd_en   = fetch_rd;
    assign mem_rd_addr = eff_addr;

    always_comb begin
        if (is_rd_h)      reg_rdata = prefetch_q[WORD_W-1:BYTE_W];
        else if (is_rd_l) reg_rdata = prefetch_q[BYTE_W-1:0];
        else              reg_rdata = '0;
    end

endmodule

// File: rtl/vport_vram_port_chk.sv
module vport_vram_port_chk
    import vport_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int LINE_W     = 9,
    parameter int FIRST_LINE = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [2:0]        reg_sel,
    input logic              blk_en,
    input logic              forced_blank,
    input logic [LINE_W-1:0] cur_line,
    input logic [LINE_W-1:0] vis_height,
    input logic              mem_wr_en,
    input logic              mem_wr_hi,
    input logic              mem_rd_en,
    input logic              inc_high,
    input logic [ADDR_W-1:0] addr_q
);

    localparam logic [LINE_W:0] FL = (LINE_W+1)'(FIRST_LINE);

    logic active_blk, data_wr;
    assign active_blk = blk_en && !forced_blank &&
                        ({1'b0, cur_line} < ({1'b0, vis_height} + FL));
    assign data_wr = reg_wr && (reg_sel == SEL_WR_L || reg_sel == SEL_WR_H);

    p_wr_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(reg_wr) &&
                      ($past(reg_sel) == SEL_WR_L || $past(reg_sel) == SEL_WR_H));

    p_hi_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_WR_H && !active_blk) |=> (mem_wr_en && mem_wr_hi));

    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && active_blk) |=> !mem_wr_en);

    p_adv_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_WR_L && !inc_high) |=> (addr_q != $past(addr_q)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_WR_H && !inc_high) |=> $stable(addr_q));

    p_ctrl_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_CTRL) |=> $stable(addr_q));

    p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_sel == SEL_PTR_L || reg_sel == SEL_PTR_H)) |=> mem_rd_en);

    p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !reg_wr && !reg_rd) |=> !mem_rd_en);

endmodule

bind vport_vram_port vport_vram_port_chk #(
    .ADDR_W    (ADDR_W),
    .LINE_W    (LINE_W),
    .FIRST_LINE(FIRST_LINE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_sel     (reg_sel),
    .blk_en      (blk_en),
    .forced_blank(forced_blank),
    .cur_line    (cur_line),
    .vis_height  (vis_height),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_hi   (mem_wr_hi),
    .mem_rd_en   (mem_rd_en),
    .inc_high    (inc_high),
    .addr_q      (addr_q)
);

// File: tb/test_vport_vram_port.sv
module test_vport_vram_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        blk_en = 1'b0, forced_blank = 1'b0;
    logic [8:0]  cur_line = '0, vis_height = 9'd224;
    logic        mem_wr_en, mem_wr_hi, mem_rd_en;
    logic [14:0] mem_wr_addr, mem_rd_addr;
    logic [7:0]  mem_wr_data;
    logic [15:0] mem_rd_data = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic        cap_we, cap_hi;
    logic [14:0] cap_addr;
    logic [7:0]  cap_data, cap_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    vport_vram_port i_vport_vram_port (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .blk_en(blk_en), .forced_blank(forced_blank), .cur_line(cur_line),
        .vis_height(vis_height), .mem_wr_en(mem_wr_en), .mem_wr_hi(mem_wr_hi),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    // Behavioural sparse memory
    logic [15:0] ram [int];
    logic [15:0] wtmp;

    function automatic logic [15:0] ram_get(int a);
        return ram.exists(a) ? ram[a] : 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= ram_get(int'(mem_rd_addr));
        if (mem_wr_en) begin
            wtmp = ram_get(int'(mem_wr_addr));
            if (mem_wr_hi) wtmp[15:8] = mem_wr_data;
            else           wtmp[7:0]  = mem_wr_data;
            ram[int'(mem_wr_addr)] = wtmp;
        end
    end

    function automatic int exp_eff(int a, int mode);
        int n, cnt, msk, r;
        if (mode == 0) return a;
        n   = 4 + mode;
        cnt = 1 << n;
        msk = (1 << (n + 3)) - 1;
        r   = a & msk;
        return ((a & ~msk) + (r >> n) + ((r & (cnt - 1)) << 3)) & 32'h7fff;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic access(bit wr, bit rd, logic [2:0] sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_sel = sel; reg_wdata = d;
        #1 cap_rdata = reg_rdata;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
        cap_we = mem_wr_en; cap_hi = mem_wr_hi;
        cap_addr = mem_wr_addr; cap_data = mem_wr_data;
    endtask

    task automatic set_ctrl(logic [7:0] c);
        access(1, 0, 3'd0, c);
    endtask

    task automatic set_ptr(int a);
        access(1, 0, 3'd1, a[7:0]);
        access(1, 0, 3'd2, a[15:8]);
        idle(3);
    endtask

    task automatic wr_lo(logic [7:0] d); access(1, 0, 3'd3, d); endtask
    task automatic wr_hi(logic [7:0] d); access(1, 0, 3'd4, d); endtask
    task automatic rd_lo(); access(0, 1, 3'd5, 8'h00); endtask
    task automatic rd_hi(); access(0, 1, 3'd6, 8'h00); endtask

    task automatic t_reset();
        chk("R1", "wr_en after reset", mem_wr_en, 0);
        chk("R1", "rd_en after reset", mem_rd_en, 0);
        wr_lo(8'h11);
        chk("R1", "pointer after reset", cap_addr, 0);
        idle(1);
        rd_hi();
        chk("R1", "prefetch after reset", cap_rdata, 0);
    endtask

    task automatic t_linear();
        set_ctrl(8'h00);
        set_ptr(16'h1234);
        wr_lo(8'hAB);
        chk("R2", "lo we", cap_we, 1);
        chk("R2", "lo lane", cap_hi, 0);
        chk("R5", "lo addr mode0", cap_addr, 16'h1234);
        chk("R2", "lo data", cap_data, 8'hAB);
        wr_hi(8'hCD);
        chk("R2", "hi lane", cap_hi, 1);
        chk("R3", "hi addr after lo advance", cap_addr, 16'h1235);
        chk("R2", "hi data", cap_data, 8'hCD);
    endtask

    task automatic t_inc_high();
        set_ctrl(8'h80);
        set_ptr(16'h0100);
        wr_lo(8'h01);
        chk("R3", "lo addr", cap_addr, 16'h0100);
        wr_hi(8'h02);
        chk("R3", "hi same word", cap_addr, 16'h0100);
        wr_lo(8'h03);
        chk("R3", "advance after hi", cap_addr, 16'h0101);
    endtask

    task automatic t_steps();
        int steps[4] = '{1, 32, 128, 128};
        for (int c = 0; c < 4; c++) begin
            set_ctrl(8'(c));
            set_ptr(16'h0040);
            wr_lo(8'h00);
            wr_lo(8'h00);
            chk("R4", $sformatf("step code %0d", c), cap_addr, 16'h0040 + steps[c]);
        end
    endtask

    task automatic t_remap();
        for (int m = 1; m < 4; m++) begin
            set_ctrl(8'(m << 2));
            set_ptr(16'h2345);
            wr_lo(8'h5A);
            chk("R5", $sformatf("mode %0d first", m), cap_addr, exp_eff(16'h2345, m));
            wr_lo(8'h5B);
            chk("R5", $sformatf("mode %0d second", m), cap_addr, exp_eff(16'h2346, m));
        end
    endtask

    task automatic t_block();
        ram[16'h0200] = 16'h5A5A;
        set_ctrl(8'h00);
        set_ptr(16'h0200);
        blk_en = 1; forced_blank = 0; vis_height = 9'd224; cur_line = 9'd10;
        wr_lo(8'hEE);
        chk("R6", "drop mid display", cap_we, 0);
        cur_line = 9'd224;
        wr_lo(8'hEE);
        chk("R6", "drop on last visible line", cap_we, 0);
        cur_line = 9'd225;
        wr_lo(8'h77);
        chk("R6", "pass after display", cap_we, 1);
        chk("R6", "pointer advanced by dropped writes", cap_addr, 16'h0202);
        cur_line = 9'd10; forced_blank = 1;
        wr_lo(8'h78);
        chk("R6", "pass in forced blank", cap_we, 1);
        chk("R6", "addr forced blank", cap_addr, 16'h0203);
        blk_en = 0; forced_blank = 0;
        wr_lo(8'h79);
        chk("R6", "pass when disabled", cap_we, 1);
        idle(2);
        set_ptr(16'h0200);
        rd_lo();
        chk("R6", "dropped write left memory", cap_rdata, 8'h5A);
    endtask

    task automatic t_prefetch();
        ram[16'h0300] = 16'hBEEF;
        ram[16'h0301] = 16'hCAFE;
        set_ctrl(8'h00);
        set_ptr(16'h0300);
        rd_hi();
        chk("R8", "hi byte read", cap_rdata, 8'hBE);
        rd_lo();
        chk("R8", "lo byte read", cap_rdata, 8'hEF);
        idle(3);
        rd_hi();
        chk("R8", "refetch after advance", cap_rdata, 8'hCA);
        rd_lo();
        chk("R8", "refetched lo", cap_rdata, 8'hFE);
        ram[exp_eff(16'h0401, 1)] = 16'h1357;
        set_ctrl(8'h04);
        set_ptr(16'h0401);
        rd_lo();
        chk("R7", "remapped prefetch", cap_rdata, 8'h57);
        ram[16'h0500] = 16'h1111;
        ram[16'h0501] = 16'h2222;
        set_ctrl(8'h80);
        set_ptr(16'h0500);
        rd_lo();
        chk("R8", "inc-high lo read", cap_rdata, 8'h11);
        idle(3);
        rd_hi();
        chk("R8", "lo read did not advance", cap_rdata, 8'h11);
        idle(3);
        rd_lo();
        chk("R8", "hi read advanced", cap_rdata, 8'h22);
    endtask

    task automatic t_ctrl_late();
        set_ctrl(8'h00);
        set_ptr(16'h0600);
        wr_lo(8'h00);
        chk("R9", "base addr", cap_addr, 16'h0600);
        set_ctrl(8'h01);
        wr_lo(8'h00);
        chk("R9", "ctrl write kept pointer", cap_addr, 16'h0601);
        wr_lo(8'h00);
        chk("R9", "new step applied", cap_addr, 16'h0621);
    endtask

    task automatic t_wrap();
        set_ctrl(8'h00);
        set_ptr(16'h7FFF);
        wr_lo(8'h00);
        wr_lo(8'h00);
        chk("R10", "wrap step 1", cap_addr, 16'h0000);
        set_ctrl(8'h02);
        set_ptr(16'h7FC0);
        wr_lo(8'h00);
        wr_lo(8'h00);
        chk("R10", "wrap step 128", cap_addr, 16'h0040);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_linear();
        t_inc_high();
        t_steps();
        t_remap();
        t_block();
        t_prefetch();
        t_ctrl_late();
        t_wrap();
        idle(2);
        finish_run();
    end

endmodule